// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the system control register file of a processor core module. A simple 32-bit register bus addresses it by word index, where the word index is the byte offset divided by four. Reads are combinational from the index. Writes take effect at the rising clock edge while the write strobe is high.

The block holds the following:
- a fixed identification word and a fixed status word;
- a pair of clock oscillator words, which can only be changed once a 16-bit key has been loaded into a guard register;
- a control register that drives a status LED, a boot-memory remap select and a reset request that clears itself;
- writable memory configuration and memory initialisation words;
- two banks of flags, each written through separate set and clear indices;
- a read-only presence-detect window that serves bytes from a small computed table.

The oscillator words, remap and LED settings leave the block as plain control outputs for the surrounding clocking and memory fabric. The reset request is a one-cycle pulse that a reset controller can consume directly. When remap is low, boot flash overlays address zero. When remap is high, the overlay is removed.

Top module: `sysctl_regs`

## Requirements
- R1: Word index 0 reads the constant 0x411A3001, and word index 4 reads the constant 0x00100000. Word index 1 reads zero.
- R2: A write to the guard register (index 5) keeps only bits 15:0. While it holds 0xA05F, it reads as 0x0001A05F, with bit 16 flagging the unlocked state. Otherwise it reads the stored 16 bits, zero-extended. It resets to zero.
- R3: Writes to the oscillator word (index 2) and the auxiliary oscillator word (index 7) are dropped unless the guard holds 0xA05F. Both words are readable at their indices, and the stored values drive `oscWord` and `auxOscWord`.
- R4: The control register is at index 3. Only bit 0 (LED) and bit 2 (remap) are stored, and every other bit reads as zero. A write with bit 3 set raises `rstReq` for exactly the one cycle after the write edge. A write with bit 3 clear raises no pulse.
- R5: `ledOut` equals stored control bit 0 and `remapOut` equals stored control bit 2. Each changes only in the cycle after a control write. Both are 0 after reset, which means the boot flash overlay is active.
- R6: Each flag bank is written through two indices. The volatile bank has set index 12 and clear index 13. The non-volatile bank has set index 14 and clear index 15. A write to a set index ORs the data into the bank. A write to a clear index clears the bits that are 1 in the data. A set index reads its bank, and a clear index reads zero. Both banks reset to zero.
- R7: The reset values are: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF and initialisation word 0x00000112.
- R8: The memory configuration word (index 8) resets to 0x00011122 ORed with a size code taken from parameter MEM_MB. The code is 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below that. The default of 128 gives 0x0001112E. Index 8 and the initialisation word (index 9) both store any written value.
- R9: Indices 64 to 95 read table byte (index − 64) in bits 7:0, with the upper bits zero. The table holds byte 0 = 0x80 and byte 1 = 0x08. Byte 31 depends on memory size: 64 for 256+, 32 for 128+, 16 for 64+, 4 for 32+, and 2 otherwise. Indices 96 to 127 read zero, and writes in 64 to 127 are dropped.
- R10: Indices 32 to 35 read zero and ignore writes.
- R11: A write to any other unlisted index changes nothing, and a read from one returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busIdx | input | IDX_W | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busIdx`, combinational |
| rstReq | output | 1 | One-cycle reset request pulse |
| remapOut | output | 1 | Remap select (1 removes the boot flash overlay) |
| ledOut | output | 1 | Status LED drive |
| oscWord | output | 32 | Oscillator setting |
| auxOscWord | output | 32 | Auxiliary oscillator setting |

## Verification
The ports show each kind of internal fault differently:
- A guard that decodes the key wrongly shows up in the guard's own read-back, including its bit 16. It also shows on the first oscillator write, because `oscWord` moves when it should hold, or holds when it should move.
- A bad control register decode is seen one cycle after the write. It shows as a missing or stretched `rstReq` pulse, or as `remapOut` or `ledOut` changing without a control write.
- Flag and table faults show only on reads, at the index that holds the corrupted state. The bench therefore reads back every register after the writes that touch it, and reads neighbouring banks to expose writes that landed in the wrong place.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  localparam logic [31:0] ID_WORD   = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD = 32'h0010_0000;
  localparam logic [15:0] GUARD_KEY = 16'hA05F;
  localparam logic [31:0] OSC_RST   = 32'h0100_0048;
  localparam logic [31:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [31:0] MEM_BASE  = 32'h0001_1122;
  localparam logic [31:0] INIT_RST  = 32'h0000_0112;

  // word indices whose values are decoded by software
  localparam int IDX_ID       = 0;
  localparam int IDX_PROC     = 1;
  localparam int IDX_OSC      = 2;
  localparam int IDX_CTRL     = 3;
  localparam int IDX_STAT     = 4;
  localparam int IDX_GUARD    = 5;
  localparam int IDX_AUX      = 7;
  localparam int IDX_MEM      = 8;
  localparam int IDX_INIT     = 9;
  localparam int IDX_FLAG_SET = 12;
  localparam int IDX_FLAG_CLR = 13;
  localparam int IDX_NV_SET   = 14;
  localparam int IDX_NV_CLR   = 15;
  localparam int IDX_SPD_BASE = 64;

  localparam int CTRL_LED_BIT   = 0;
  localparam int CTRL_REMAP_BIT = 2;
  localparam int CTRL_RESET_BIT = 3;

  localparam int FLAG_BANKS = 2;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_STAT, RD_OSC, RD_CTRL, RD_GUARD, RD_AUX,
    RD_MEM, RD_INIT, RD_FLAG, RD_NVFLAG, RD_SPD
  } rdSel_e;

  typedef struct packed {
    logic                  wrOsc;
    logic                  wrCtrl;
    logic                  wrGuard;
    logic                  wrAux;
    logic                  wrMem;
    logic                  wrInit;
    logic [FLAG_BANKS-1:0] flagSet;
    logic [FLAG_BANKS-1:0] flagClr;
    rdSel_e                rdSel;
  } strobe_t;

  function automatic logic [31:0] sizeCode(input int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] sizeByte(input int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] spdByte(input int idx, input int mb);
    case (idx)
      0:  return 8'h80;  1:  return 8'h08;  2:  return 8'h04;  3:  return 8'h0B;
      4:  return 8'h09;  5:  return 8'h01;  6:  return 8'h40;  7:  return 8'h00;
      8:  return 8'h02;  9:  return 8'hA0;  10: return 8'hA0;  11: return 8'h00;
      12: return 8'h00;  13: return 8'h08;  14: return 8'h00;  15: return 8'h01;
      16: return 8'h0E;  17: return 8'h04;  18: return 8'h1C;  19: return 8'h01;
      20: return 8'h02;  21: return 8'h20;  22: return 8'hC0;  23: return 8'h00;
      24: return 8'h00;  25: return 8'h00;  26: return 8'h00;  27: return 8'h30;
      28: return 8'h28;  29: return 8'h30;  30: return 8'h28;
      31: return sizeByte(mb);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctl.sv
module sysctl_ctl
  import sysctl_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int SPD_DEPTH = 32
) (
  input  logic             busWr,
  input  logic [IDX_W-1:0] busIdx,
  input  logic             unlocked,
  output strobe_t          stb
);

  localparam int SPD_LAST = IDX_SPD_BASE + SPD_DEPTH - 1;

  logic [31:0] idxN;

  always_comb begin
    idxN      = 32'(busIdx);
    stb       = '0;
    stb.rdSel = RD_ZERO;
    case (idxN)
      IDX_ID:    stb.rdSel = RD_ID;
      IDX_STAT:  stb.rdSel = RD_STAT;
      IDX_OSC: begin
        stb.rdSel = RD_OSC;
        stb.wrOsc = busWr & unlocked;
      end
      IDX_CTRL: begin
        stb.rdSel  = RD_CTRL;
        stb.wrCtrl = busWr;
      end
      IDX_GUARD: begin
        stb.rdSel   = RD_GUARD;
        stb.wrGuard = busWr;
      end
      IDX_AUX: begin
        stb.rdSel = RD_AUX;
        stb.wrAux = busWr & unlocked;
      end
      IDX_MEM: begin
        stb.rdSel = RD_MEM;
        stb.wrMem = busWr;
      end
      IDX_INIT: begin
        stb.rdSel  = RD_INIT;
        stb.wrInit = busWr;
      end
      IDX_FLAG_SET: begin
        stb.rdSel      = RD_FLAG;
        stb.flagSet[0] = busWr;
      end
      IDX_FLAG_CLR: stb.flagClr[0] = busWr;
      IDX_NV_SET: begin
        stb.rdSel      = RD_NVFLAG;
        stb.flagSet[1] = busWr;
      end
      IDX_NV_CLR: stb.flagClr[1] = busWr;
      default: begin
        if (idxN >= 32'(IDX_SPD_BASE) && idxN <= 32'(SPD_LAST))
          stb.rdSel = RD_SPD;
      end
    endcase
  end

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setEn,
  input  logic         clrEn,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= '0;
    else if (setEn) q <= q | wdata;
    else if (clrEn) q <= q & ~wdata;
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int MEM_MB    = 128,
  parameter int SPD_DEPTH = 32,
  localparam int SPD_AW   = $clog2(SPD_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SPD_AW-1:0] spdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              unlocked,
  output logic              rstReq,
  output logic              remapOut,
  output logic              ledOut,
  output logic [DATA_W-1:0] oscWord,
  output logic [DATA_W-1:0] auxOscWord
);

  localparam logic [DATA_W-1:0] MEM_RST = MEM_BASE | sizeCode(MEM_MB);

  logic [15:0]       guardReg;
  logic [DATA_W-1:0] memReg;
  logic [DATA_W-1:0] initReg;
  logic [DATA_W-1:0] flagWord [FLAG_BANKS];
  logic [7:0]        spdRom   [SPD_DEPTH];

  assign unlocked = (guardReg == GUARD_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscWord    <= OSC_RST;
      auxOscWord <= AUX_RST;
      guardReg   <= '0;
      memReg     <= MEM_RST;
      initReg    <= INIT_RST;
      ledOut     <= 1'b0;
      remapOut   <= 1'b0;
      rstReq     <= 1'b0;
    end else begin
      rstReq <= stb.wrCtrl & wdata[CTRL_RESET_BIT];
      if (stb.wrOsc)   oscWord    <= wdata;
      if (stb.wrAux)   auxOscWord <= wdata;
      if (stb.wrGuard) guardReg   <= wdata[15:0];
      if (stb.wrMem)   memReg     <= wdata;
      if (stb.wrInit)  initReg    <= wdata;
      if (stb.wrCtrl) begin
        ledOut   <= wdata[CTRL_LED_BIT];
        remapOut <= wdata[CTRL_REMAP_BIT];
      end
    end
  end

  for (genvar b = 0; b < FLAG_BANKS; b++) begin : g_bank
    sysctl_setclr #(.W(DATA_W)) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .setEn (stb.flagSet[b]),
      .clrEn (stb.flagClr[b]),
      .wdata (wdata),
      .q     (flagWord[b])
    );
  end

  for (genvar i = 0; i < SPD_DEPTH; i++) begin : g_spd
    assign spdRom[i] = spdByte(i, MEM_MB);
  end

  always_comb begin
    case (stb.rdSel)
      RD_ID:     rdData = ID_WORD;
      RD_STAT:   rdData = STAT_WORD;
      RD_OSC:    rdData = oscWord;
      RD_AUX:    rdData = auxOscWord;
      RD_CTRL:   rdData = {29'b0, remapOut, 1'b0, ledOut};
      RD_GUARD:  rdData = {15'b0, unlocked, guardReg};
      RD_MEM:    rdData = memReg;
      RD_INIT:   rdData = initReg;
      RD_FLAG:   rdData = flagWord[0];
      RD_NVFLAG: rdData = flagWord[1];
      RD_SPD:    rdData = {24'b0, spdRom[spdIdx]};
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MEM_MB    = 128,
  parameter int SPD_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [IDX_W-1:0] busIdx,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             rstReq,
  output logic             remapOut,
  output logic             ledOut,
  output logic [31:0]      oscWord,
  output logic [31:0]      auxOscWord
);

  localparam int SPD_AW = $clog2(SPD_DEPTH);

  strobe_t stb;
  logic    unlocked;

  sysctl_ctl #(.IDX_W(IDX_W), .SPD_DEPTH(SPD_DEPTH)) u_ctl (
    .busWr    (busWr),
    .busIdx   (busIdx),
    .unlocked (unlocked),
    .stb      (stb)
  );

  sysctl_dp #(.MEM_MB(MEM_MB), .SPD_DEPTH(SPD_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .spdIdx     (busIdx[SPD_AW-1:0]),
    .rdData     (busRdata),
    .unlocked   (unlocked),
    .rstReq     (rstReq),
    .remapOut   (remapOut),
    .ledOut     (ledOut),
    .oscWord    (oscWord),
    .auxOscWord (auxOscWord)
  );

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk
  import sysctl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [IDX_W-1:0] busIdx,
  input logic             wrResetBit,
  input logic [31:0]      busRdata,
  input logic             rstReq,
  input logic             remapOut,
  input logic             ledOut,
  input logic [31:0]      oscWord,
  input logic [31:0]      auxOscWord
);

  logic [31:0] idxN;
  logic        ctrlHit, oscHit, auxHit, voltHit, spdZeroHit;

  assign idxN       = 32'(busIdx);
  assign ctrlHit    = (idxN == 32'(IDX_CTRL));
  assign oscHit     = (idxN == 32'(IDX_OSC));
  assign auxHit     = (idxN == 32'(IDX_AUX));
  assign voltHit    = (idxN >= 32'd32) && (idxN <= 32'd35);
  assign spdZeroHit = (idxN >= 32'd96) && (idxN <= 32'd127);

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (idxN == 32'(IDX_ID)) |-> (busRdata == ID_WORD)); // R1

  AST_CTRL_READ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |-> (busRdata[31:3] == 29'd0 && busRdata[1] == 1'b0)); // R4

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(busWr && ctrlHit && wrResetBit)); // R4

  AST_REMAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapOut) |-> $past(busWr && ctrlHit)); // R5

  AST_LED_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ledOut) |-> $past(busWr && ctrlHit)); // R5

  AST_OSC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oscWord) |-> $past(busWr && oscHit)); // R3

  AST_AUX_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(auxOscWord) |-> $past(busWr && auxHit)); // R3

  AST_VOLT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    voltHit |-> (busRdata == 32'd0)); // R10

  AST_SPD_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    spdZeroHit |-> (busRdata == 32'd0)); // R9

endmodule

bind sysctl_regs sysctl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .busIdx     (busIdx),
  .wrResetBit (busWdata[3]),
  .busRdata   (busRdata),
  .rstReq     (rstReq),
  .remapOut   (remapOut),
  .ledOut     (ledOut),
  .oscWord    (oscWord),
  .auxOscWord (auxOscWord)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;

  localparam int IDX_W = 8;

  typedef struct packed {
    logic        wr;
    logic [7:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 46;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd0,   32'h0,        32'h411A3001, 4'd1},  // R1 id
    '{1'b0, 8'd4,   32'h0,        32'h00100000, 4'd1},  // R1 status
    '{1'b0, 8'd1,   32'h0,        32'h00000000, 4'd1},  // R1 index 1 zero
    '{1'b0, 8'd2,   32'h0,        32'h01000048, 4'd7},  // R7 osc reset
    '{1'b0, 8'd7,   32'h0,        32'h0007FEFF, 4'd7},  // R7 aux reset
    '{1'b0, 8'd8,   32'h0,        32'h0001112E, 4'd8},  // R8 size code 128
    '{1'b0, 8'd9,   32'h0,        32'h00000112, 4'd7},  // R7 init reset
    '{1'b0, 8'd5,   32'h0,        32'h00000000, 4'd2},  // R2 guard reset
    '{1'b1, 8'd2,   32'h12345678, 32'h0,        4'd3},  // R3 locked write
    '{1'b0, 8'd2,   32'h0,        32'h01000048, 4'd3},  // R3 dropped
    '{1'b1, 8'd5,   32'hFFFFA05F, 32'h0,        4'd2},  // R2 key, upper dropped
    '{1'b0, 8'd5,   32'h0,        32'h0001A05F, 4'd2},  // R2 unlocked readback
    '{1'b1, 8'd2,   32'h12345678, 32'h0,        4'd3},  // R3
    '{1'b0, 8'd2,   32'h0,        32'h12345678, 4'd3},  // R3 accepted
    '{1'b1, 8'd7,   32'h0000ABCD, 32'h0,        4'd3},  // R3
    '{1'b0, 8'd7,   32'h0,        32'h0000ABCD, 4'd3},  // R3 aux accepted
    '{1'b1, 8'd5,   32'h00001234, 32'h0,        4'd2},  // R2 relock
    '{1'b0, 8'd5,   32'h0,        32'h00001234, 4'd2},  // R2 plain readback
    '{1'b1, 8'd7,   32'h00000000, 32'h0,        4'd3},  // R3 locked again
    '{1'b0, 8'd7,   32'h0,        32'h0000ABCD, 4'd3},  // R3 held
    '{1'b1, 8'd12,  32'h000000F0, 32'h0,        4'd6},  // R6 set
    '{1'b1, 8'd12,  32'h0000000F, 32'h0,        4'd6},  // R6 set accumulates
    '{1'b0, 8'd12,  32'h0,        32'h000000FF, 4'd6},  // R6
    '{1'b1, 8'd13,  32'h0000003C, 32'h0,        4'd6},  // R6 clear
    '{1'b0, 8'd12,  32'h0,        32'h000000C3, 4'd6},  // R6
    '{1'b0, 8'd13,  32'h0,        32'h00000000, 4'd6},  // R6 clear index reads 0
    '{1'b1, 8'd14,  32'hA5000000, 32'h0,        4'd6},  // R6 nv set
    '{1'b1, 8'd15,  32'h05000000, 32'h0,        4'd6},  // R6 nv clear
    '{1'b0, 8'd14,  32'h0,        32'hA0000000, 4'd6},  // R6
    '{1'b0, 8'd12,  32'h0,        32'h000000C3, 4'd6},  // R6 other bank intact
    '{1'b0, 8'd64,  32'h0,        32'h00000080, 4'd9},  // R9 byte 0
    '{1'b0, 8'd65,  32'h0,        32'h00000008, 4'd9},  // R9 byte 1
    '{1'b0, 8'd95,  32'h0,        32'h00000020, 4'd9},  // R9 byte 31 size
    '{1'b0, 8'd96,  32'h0,        32'h00000000, 4'd9},  // R9 tail zero
    '{1'b0, 8'd127, 32'h0,        32'h00000000, 4'd9},  // R9 tail zero
    '{1'b1, 8'd32,  32'hFFFFFFFF, 32'h0,        4'd10}, // R10
    '{1'b0, 8'd32,  32'h0,        32'h00000000, 4'd10}, // R10
    '{1'b0, 8'd35,  32'h0,        32'h00000000, 4'd10}, // R10
    '{1'b1, 8'd40,  32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    '{1'b0, 8'd40,  32'h0,        32'h00000000, 4'd11}, // R11
    '{1'b1, 8'd8,   32'hDEADBEEF, 32'h0,        4'd8},  // R8
    '{1'b0, 8'd8,   32'h0,        32'hDEADBEEF, 4'd8},  // R8
    '{1'b1, 8'd9,   32'h00000ABC, 32'h0,        4'd8},  // R8 init writable
    '{1'b0, 8'd9,   32'h0,        32'h00000ABC, 4'd8},  // R8
    '{1'b1, 8'd3,   32'h00000007, 32'h0,        4'd4},  // R4
    '{1'b0, 8'd3,   32'h0,        32'h00000005, 4'd4}   // R4 only bits 0,2
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWr = 1'b0;
  logic [IDX_W-1:0] busIdx = '0;
  logic [31:0]      busWdata = '0;
  logic [31:0]      busRdata;
  logic             rstReq, remapOut, ledOut;
  logic [31:0]      oscWord, auxOscWord;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysctl_regs #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busIdx(busIdx),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq),
    .remapOut(remapOut), .ledOut(ledOut), .oscWord(oscWord),
    .auxOscWord(auxOscWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busIdx = idx; busWdata = data;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [7:0] idx, input string req, input logic [31:0] exp);
    @(negedge clk);
    busIdx = idx;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state at the ports
    check("R7 osc out", oscWord, 32'h01000048);
    check("R7 aux out", auxOscWord, 32'h0007FEFF);
    check("R5 remap", {31'b0, remapOut}, 32'd0);
    check("R5 led", {31'b0, ledOut}, 32'd0);
    check("R4 rstReq", {31'b0, rstReq}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) doWrite(VECS[i].idx, VECS[i].data);
      else doRead(VECS[i].idx, $sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].exp);
    end

    // control write of 7 stored LED and remap
    check("R5 remap after ctrl", {31'b0, remapOut}, 32'd1);
    check("R5 led after ctrl", {31'b0, ledOut}, 32'd1);
    check("R4 no pulse without bit3", {31'b0, rstReq}, 32'd0);

    // reset request pulse: one cycle only
    @(negedge clk);
    busWr = 1'b1; busIdx = 8'd3; busWdata = 32'h8;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
    check("R4 pulse high", {31'b0, rstReq}, 32'd1);
    check("R5 remap cleared", {31'b0, remapOut}, 32'd0);
    check("R5 led cleared", {31'b0, ledOut}, 32'd0);
    @(negedge clk);
    check("R4 pulse ends", {31'b0, rstReq}, 32'd0);
    doRead(8'd3, "R4 reset bit reads 0", 32'd0);

    doWrite(8'd3, 32'h4);
    check("R4 no pulse", {31'b0, rstReq}, 32'd0);
    check("R5 remap set", {31'b0, remapOut}, 32'd1);
    check("R5 led off", {31'b0, ledOut}, 32'd0);

    // guard holds 0x1234: osc output must not move
    check("R3 osc out", oscWord, 32'h12345678);
    doWrite(8'd2, 32'h0BADF00D);
    check("R3 osc out held", oscWord, 32'h12345678);
    check("R3 aux out", auxOscWord, 32'h0000ABCD);

    // writes in the table window are dropped
    doWrite(8'd64, 32'hFFFFFFFF);
    doRead(8'd64, "R9 window write dropped", 32'h80);

    done = 1'b1;
    finishRun();
  end

endmodule